// File: doc/BRIEF.md
# Clock Synthesiser Configuration Register Bank

This block is a small slave register bank on a simple 32-bit memory-mapped bus. It gives software three things. The first is a run/enable register: one bit takes the clock logic out of reset and another bit enables the clock-synthesis primitive. The second is a register that picks one of two input clocks. The third is an indirect window onto the 16-bit dynamic reconfiguration port of the primitive.

Software writes one control word, and that write starts a single reconfiguration transaction, either a read or a write. While the transaction is in flight, a busy flag in the status word stays set. When it finishes, the same status word holds the data returned by the most recent read. The bus uses plain strobes. A write takes effect at the clock edge where `wr_en_i` is sampled high. A read returns its value on `rd_data_o` in the cycle after `rd_en_i`, and `rd_data_o` is zero in any cycle that follows no read.

Top module: `clkcfg_regbank`

## Requirements
- R1: After reset, every mapped register reads zero, busy (status bit 16) is clear, and `drp_en_o`, `core_run_o`, `prim_en_o` and `src_sel_o` are low.
- R2: The run register sits at byte offset 0x40. Bit 0 drives `core_run_o` and bit 1 drives `prim_en_o`. A read returns those two bits in the same positions, and bits 31:2 read zero.
- R3: The source-select register sits at offset 0x44. Bit 0 drives `src_sel_o` and reads back at bit 0. Bits 31:1 are dropped and read zero.
- R4: The control word sits at offset 0x70. Bit 29 is the target select and drives `drp_sel_o`. Bit 28 set means read and clear means write, so `drp_we_o` is high with the enable pulse only for writes. Bits 15:0 are the write data on `drp_di_o`. A read of offset 0x70 returns the stored fields in those same positions.
- R5: When the control word is written while idle, busy reads 1 from the following cycle on, and `drp_en_o` is high for exactly that one cycle.
- R6: Busy clears at the clock edge where `drp_rdy_i` is sampled high while busy. A `drp_rdy_i` pulse while idle changes nothing.
- R7: Status bits 15:0 hold the `drp_do_i` value captured when a read transaction completes. Completing a write leaves them unchanged.
- R8: A control write while busy is dropped. No enable pulse follows, and the stored control word stays the same.
- R9: The transaction address is control bits 22:16, driven on the 7-bit `drp_addr_o`. Control bits 27:23 are ignored and read back as zero.
- R10: A read of any offset other than 0x40, 0x44, 0x70 or 0x74 returns zero. A write to such an offset changes no register. `rd_data_o` is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| core_run_o | output | 1 | Clock logic out of reset |
| prim_en_o | output | 1 | Clock primitive enable |
| src_sel_o | output | 1 | Input clock index |
| drp_sel_o | output | 1 | Target select from control bit 29 |
| drp_en_o | output | 1 | One-cycle transaction enable |
| drp_we_o | output | 1 | Write qualifier for the enable pulse |
| drp_addr_o | output | 7 | Transaction register address |
| drp_di_o | output | 16 | Transaction write data |
| drp_do_i | input | 16 | Read data from the port |
| drp_rdy_i | input | 1 | Transaction completion strobe |

## Verification
The bench issues a second control write while the first transaction is still waiting for its ready. A design that did not block this write would pulse the enable again or overwrite the stored address, and a later read-back of that address would return the wrong word. It drives a stray ready while idle, which a careless design would take as a completion and use to change the captured data. It also writes control words with address bits above bit 22 set, to catch an address field that is too wide. A read that follows a write must leave the captured data intact, and varying the port latency catches a busy flag that clears on a fixed count instead of on ready.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int unsigned OFS_RUN    = 32'h40;
    localparam int unsigned OFS_SRCSEL = 32'h44;
    localparam int unsigned OFS_CTRL   = 32'h70;
    localparam int unsigned OFS_STATUS = 32'h74;

    localparam int unsigned CTL_SEL_BIT  = 29;
    localparam int unsigned CTL_RD_BIT   = 28;
    localparam int unsigned CTL_ADDR_LSB = 16;
    localparam int unsigned STS_BUSY_BIT = 16;

    localparam int unsigned BUS_DW = 32;
endpackage

// File: rtl/clkcfg_cfg_regs.sv
module clkcfg_cfg_regs
    import clkcfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16,
    parameter int unsigned SRC_W  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BUS_DW-1:0] wr_data_i,
    input  logic              busy_i,
    output logic              run_o,
    output logic              prim_en_o,
    output logic [SRC_W-1:0]  src_sel_o,
    output logic              ctl_sel_o,
    output logic              ctl_rd_o,
    output logic [DRP_AW-1:0] ctl_addr_o,
    output logic [DRP_DW-1:0] ctl_data_o,
    output logic              launch_o
);
    typedef struct packed {
        logic              run;
        logic              prim_en;
        logic [SRC_W-1:0]  src;
        logic              sel;
        logic              rd;
        logic [DRP_AW-1:0] addr;
        logic [DRP_DW-1:0] data;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic hit_run, hit_src, hit_ctrl;
    logic unused_wr;

    assign hit_run  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_RUN));
    assign hit_src  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_SRCSEL));
    assign hit_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CTRL));
    assign launch_o = hit_ctrl && !busy_i;
    assign unused_wr = ^wr_data_i;

    always_comb begin
        cfg_d = cfg_q;
        if (hit_run) begin
            cfg_d.run     = wr_data_i[0];
            cfg_d.prim_en = wr_data_i[1];
        end
        if (hit_src) begin
            cfg_d.src = wr_data_i[SRC_W-1:0];
        end
        if (launch_o) begin
            cfg_d.sel  = wr_data_i[CTL_SEL_BIT];
            cfg_d.rd   = wr_data_i[CTL_RD_BIT];
            cfg_d.addr = wr_data_i[CTL_ADDR_LSB +: DRP_AW];
            cfg_d.data = wr_data_i[DRP_DW-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign run_o      = cfg_q.run;
    assign prim_en_o  = cfg_q.prim_en;
    assign src_sel_o  = cfg_q.src;
    assign ctl_sel_o  = cfg_q.sel;
    assign ctl_rd_o   = cfg_q.rd;
    assign ctl_addr_o = cfg_q.addr;
    assign ctl_data_o = cfg_q.data;

    AST_CTRL_FROZEN_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_ctrl && busy_i) |=> $stable({ctl_sel_o, ctl_rd_o, ctl_addr_o, ctl_data_o})); // R8
endmodule

// File: rtl/clkcfg_drp_engine.sv
module clkcfg_drp_engine #(
    parameter int unsigned DRP_DW = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              launch_i,
    input  logic              ctl_rd_i,
    input  logic              drp_rdy_i,
    input  logic [DRP_DW-1:0] drp_do_i,
    output logic              drp_en_o,
    output logic              drp_we_o,
    output logic              busy_o,
    output logic [DRP_DW-1:0] rdata_o
);
    typedef struct packed {
        logic              busy;
        logic              en;
        logic [DRP_DW-1:0] rdata;
    } eng_t;

    eng_t eng_d, eng_q;
    logic done;

    assign done = eng_q.busy && drp_rdy_i;

    always_comb begin
        eng_d    = eng_q;
        eng_d.en = 1'b0;
        if (launch_i) begin
            eng_d.busy = 1'b1;
            eng_d.en   = 1'b1;
        end else if (done) begin
            eng_d.busy = 1'b0;
            if (ctl_rd_i) eng_d.rdata = drp_do_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) eng_q <= '0;
        else         eng_q <= eng_d;
    end

    assign drp_en_o = eng_q.en;
    assign drp_we_o = eng_q.en && !ctl_rd_i;
    assign busy_o   = eng_q.busy;
    assign rdata_o  = eng_q.rdata;

    AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        launch_i |=> (busy_o && drp_en_o)); // R5
    AST_EN_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drp_en_o |=> !drp_en_o); // R5
    AST_READY_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && drp_rdy_i) |=> !busy_o); // R6
    AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && drp_rdy_i && ctl_rd_i) |=> $stable(rdata_o)); // R7
endmodule

// File: rtl/clkcfg_rd_mux.sv
module clkcfg_rd_mux
    import clkcfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16,
    parameter int unsigned SRC_W  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              run_i,
    input  logic              prim_en_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic              ctl_sel_i,
    input  logic              ctl_rd_i,
    input  logic [DRP_AW-1:0] ctl_addr_i,
    input  logic [DRP_DW-1:0] ctl_data_i,
    input  logic              busy_i,
    input  logic [DRP_DW-1:0] rdata_i,
    output logic [BUS_DW-1:0] rd_data_o
);
    logic [BUS_DW-1:0] word;
    logic [BUS_DW-1:0] rd_d, rd_q;

    always_comb begin
        word = '0;
        if (rd_addr_i == ADDR_W'(OFS_RUN)) begin
            word[0] = run_i;
            word[1] = prim_en_i;
        end else if (rd_addr_i == ADDR_W'(OFS_SRCSEL)) begin
            word[SRC_W-1:0] = src_i;
        end else if (rd_addr_i == ADDR_W'(OFS_CTRL)) begin
            word[CTL_SEL_BIT]              = ctl_sel_i;
            word[CTL_RD_BIT]               = ctl_rd_i;
            word[CTL_ADDR_LSB +: DRP_AW]   = ctl_addr_i;
            word[DRP_DW-1:0]               = ctl_data_i;
        end else if (rd_addr_i == ADDR_W'(OFS_STATUS)) begin
            word[STS_BUSY_BIT] = busy_i;
            word[DRP_DW-1:0]   = rdata_i;
        end
        rd_d = rd_en_i ? word : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;

    AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rd_data_o == '0)); // R10
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16,
    parameter int unsigned SRC_W  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              core_run_o,
    output logic              prim_en_o,
    output logic [SRC_W-1:0]  src_sel_o,
    output logic              drp_sel_o,
    output logic              drp_en_o,
    output logic              drp_we_o,
    output logic [DRP_AW-1:0] drp_addr_o,
    output logic [DRP_DW-1:0] drp_di_o,
    input  logic [DRP_DW-1:0] drp_do_i,
    input  logic              drp_rdy_i
);
    logic              busy, launch, ctl_rd;
    logic [DRP_DW-1:0] rdata;

    clkcfg_cfg_regs #(
        .ADDR_W(ADDR_W), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW), .SRC_W(SRC_W)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .busy_i     (busy),
        .run_o      (core_run_o),
        .prim_en_o  (prim_en_o),
        .src_sel_o  (src_sel_o),
        .ctl_sel_o  (drp_sel_o),
        .ctl_rd_o   (ctl_rd),
        .ctl_addr_o (drp_addr_o),
        .ctl_data_o (drp_di_o),
        .launch_o   (launch)
    );

    clkcfg_drp_engine #(.DRP_DW(DRP_DW)) u_engine (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .launch_i  (launch),
        .ctl_rd_i  (ctl_rd),
        .drp_rdy_i (drp_rdy_i),
        .drp_do_i  (drp_do_i),
        .drp_en_o  (drp_en_o),
        .drp_we_o  (drp_we_o),
        .busy_o    (busy),
        .rdata_o   (rdata)
    );

    clkcfg_rd_mux #(
        .ADDR_W(ADDR_W), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW), .SRC_W(SRC_W)
    ) u_rd (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .run_i      (core_run_o),
        .prim_en_i  (prim_en_o),
        .src_i      (src_sel_o),
        .ctl_sel_i  (drp_sel_o),
        .ctl_rd_i   (ctl_rd),
        .ctl_addr_i (drp_addr_o),
        .ctl_data_i (drp_di_o),
        .busy_i     (busy),
        .rdata_i    (rdata),
        .rd_data_o  (rd_data_o)
    );

    AST_NO_PULSE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |=> !($rose(drp_en_o) && $past(busy))); // R8
endmodule

// File: tb/tb_clkcfg_regbank.sv
module tb_clkcfg_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        core_run, prim_en, drp_sel, drp_en, drp_we;
    logic [0:0]  src_sel;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do = '0;
    logic        drp_rdy = 1'b0;

    int checks = 0, fails = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    clkcfg_regbank dut (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .core_run_o(core_run), .prim_en_o(prim_en), .src_sel_o(src_sel),
        .drp_sel_o(drp_sel), .drp_en_o(drp_en), .drp_we_o(drp_we),
        .drp_addr_o(drp_addr), .drp_di_o(drp_di),
        .drp_do_i(drp_do), .drp_rdy_i(drp_rdy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // behavioural port model: register array with adjustable latency
    logic [15:0] drp_mem [128];
    int          lat = 1;
    int          cnt = 0;
    logic [6:0]  p_addr;
    logic        p_we;
    logic [15:0] p_di;
    bit          spur = 1'b0;

    initial begin
        for (int i = 0; i < 128; i++) drp_mem[i] = 16'h4000 + 16'(i * 3);
    end

    always @(negedge clk) begin
        drp_rdy <= 1'b0;
        if (spur) begin
            drp_rdy <= 1'b1;
            drp_do  <= 16'hDEAD;
        end
        if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                drp_rdy <= 1'b1;
                drp_do  <= drp_mem[p_addr];
                if (p_we) drp_mem[p_addr] = p_di;
            end
        end
        if (drp_en === 1'b1) begin
            p_addr = drp_addr;
            p_we   = drp_we;
            p_di   = drp_di;
            cnt    = lat;
        end
    end

    // cycle reference model
    logic        m_run = 0, m_pe = 0, m_src = 0, m_csel = 0, m_crd = 0;
    logic [6:0]  m_caddr = '0;
    logic [15:0] m_cdata = '0, m_rdata = '0;
    logic        m_busy = 0, m_en = 0;
    logic [31:0] m_rd = '0;
    logic        was_busy;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pe = 0; m_src = 0; m_csel = 0; m_crd = 0;
            m_caddr = '0; m_cdata = '0; m_rdata = '0;
            m_busy = 0; m_en = 0; m_rd = '0;
        end else begin
            m_rd = '0;
            if (rd_en) begin
                case (rd_addr)
                    8'h40: m_rd = {30'd0, m_pe, m_run};
                    8'h44: m_rd = {31'd0, m_src};
                    8'h70: m_rd = {2'b00, m_csel, m_crd, 5'd0, m_caddr, m_cdata};
                    8'h74: m_rd = {15'd0, m_busy, m_rdata};
                    default: m_rd = '0;
                endcase
            end
            was_busy = m_busy;
            m_en = 0;
            if (m_busy && drp_rdy) begin
                m_busy = 0;
                if (m_crd) m_rdata = drp_do;
            end
            if (wr_en) begin
                case (wr_addr)
                    8'h40: begin m_run = wr_data[0]; m_pe = wr_data[1]; end
                    8'h44: m_src = wr_data[0];
                    8'h70: if (!was_busy) begin
                        m_csel = wr_data[29]; m_crd = wr_data[28];
                        m_caddr = wr_data[22:16]; m_cdata = wr_data[15:0];
                        m_en = 1; m_busy = 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R10 rd_data", rd_data, m_rd);
            chk("R2 core_run", 32'(core_run), 32'(m_run));
            chk("R2 prim_en", 32'(prim_en), 32'(m_pe));
            chk("R3 src_sel", 32'(src_sel), 32'(m_src));
            chk("R5 drp_en", 32'(drp_en), 32'(m_en));
            if (m_en) begin
                chk("R9 drp_addr", 32'(drp_addr), 32'(m_caddr));
                chk("R4 drp_we", 32'(drp_we), 32'(!m_crd));
                chk("R4 drp_di", 32'(drp_di), 32'(m_cdata));
                chk("R4 drp_sel", 32'(drp_sel), 32'(m_csel));
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = '0;
        v = rd_data;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 60; i++) begin
            bus_rd(8'h74, v);
            if (v[16] == 1'b0) break;
        end
        chk("R6 busy cleared", 32'(v[16]), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 run reg", 8'h40, 32'h0);
        rd_chk("R1 srcsel reg", 8'h44, 32'h0);
        rd_chk("R1 ctrl reg", 8'h70, 32'h0);
        rd_chk("R1 status reg", 8'h74, 32'h0);
        chk("R1 drp_en", 32'(drp_en), 32'd0);

        // R2 run register
        bus_wr(8'h40, 32'h1);
        chk("R2 run only", {30'd0, prim_en, core_run}, 32'h1);
        rd_chk("R2 readback", 8'h40, 32'h1);
        bus_wr(8'h40, 32'h3);
        rd_chk("R2 both bits", 8'h40, 32'h3);
        bus_wr(8'h40, 32'hFFFF_FFFE);
        rd_chk("R2 upper bits dropped", 8'h40, 32'h2);

        // R3 source select
        bus_wr(8'h44, 32'h1);
        chk("R3 select one", 32'(src_sel), 32'd1);
        rd_chk("R3 readback", 8'h44, 32'h1);
        bus_wr(8'h44, 32'hFFFF_FFFE);
        rd_chk("R3 upper bits dropped", 8'h44, 32'h0);

        // R4 R5 write transaction, latency 1
        lat = 1;
        bus_wr(8'h70, 32'h2015_BEEF);
        chk("R5 enable pulse", 32'(drp_en), 32'd1);
        chk("R4 write qualifier", 32'(drp_we), 32'd1);
        chk("R9 address", 32'(drp_addr), 32'h15);
        bus_rd(8'h74, v);
        chk("R5 busy after launch", 32'(v[16]), 32'd1);
        chk("R5 enable one cycle", 32'(drp_en), 32'd0);
        wait_idle();
        rd_chk("R7 write keeps data", 8'h74, 32'h0000_0000);
        rd_chk("R4 ctrl readback", 8'h70, 32'h2015_BEEF);

        // R7 read transaction
        bus_wr(8'h70, 32'h3015_0000);
        chk("R4 read has no we", 32'(drp_we), 32'd0);
        wait_idle();
        rd_chk("R7 captured data", 8'h74, 32'h0000_BEEF);

        // R9 high address bits ignored
        bus_wr(8'h70, 32'h3F95_0000);
        chk("R9 masked address", 32'(drp_addr), 32'h15);
        wait_idle();
        rd_chk("R9 ctrl readback", 8'h70, 32'h3015_0000);
        rd_chk("R9 read data", 8'h74, 32'h0000_BEEF);

        // R8 write while busy dropped, latency 6
        lat = 6;
        bus_wr(8'h70, 32'h2022_1234);
        bus_wr(8'h70, 32'h3033_5555);
        chk("R8 no second pulse", 32'(drp_en), 32'd0);
        rd_chk("R8 ctrl unchanged", 8'h70, 32'h2022_1234);
        wait_idle();
        bus_wr(8'h70, 32'h3022_0000);
        wait_idle();
        rd_chk("R8 first write landed", 8'h74, 32'h0000_1234);
        bus_wr(8'h70, 32'h3033_0000);
        wait_idle();
        rd_chk("R8 dropped write absent", 8'h74, 32'h0000_4099);

        // R6 stray ready while idle
        @(negedge clk);
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        rd_chk("R6 stray ready ignored", 8'h74, 32'h0000_4099);

        // R4 target select clear
        lat = 2;
        bus_wr(8'h70, 32'h0005_0042);
        chk("R4 select low", 32'(drp_sel), 32'd0);
        wait_idle();

        // R10 unmapped offsets
        rd_chk("R10 unmapped read", 8'h48, 32'h0);
        bus_wr(8'h48, 32'hFFFF_FFFF);
        rd_chk("R10 run unchanged", 8'h40, 32'h2);
        rd_chk("R10 srcsel unchanged", 8'h44, 32'h0);
        @(negedge clk);
        chk("R10 idle read zero", rd_data, 32'h0);

        // R1 reset mid operation
        lat = 8;
        bus_wr(8'h70, 32'h3001_0000);
        do_reset();
        rd_chk("R1 status after reset", 8'h74, 32'h0);
        rd_chk("R1 run after reset", 8'h40, 32'h0);
        rd_chk("R1 ctrl after reset", 8'h70, 32'h0);
        repeat (12) @(negedge clk);
        rd_chk("R6 late ready after reset", 8'h74, 32'h0);

        finish_sim();
    end
endmodule